// File: doc/BRIEF.md
# PWM Control Bank

This block is the shared register front end for a group of PWM channels. It sits on a simple register bus with an address, write data, a write strobe, a read strobe and a registered read-data return. Software starts channels through a set register and stops them through a separate clear register. It observes which channels are running through a read-only status word. It collects per-channel update-done events in an interrupt flag word that empties itself when read.

A stop request does not halt a channel at once. The channel keeps its running bit until its waveform generator reports the end of the current period, so the status word lags the request. Each channel also owns a fixed-size register window above a base offset. The bank decodes accesses to a window into a one-hot write or read strobe plus a local offset for the channel blocks. It returns the addressed channel's read data on the bus.

Top module: `pwm_ctl_bank`

## Requirements
- R1: After a synchronous active-low reset, every running bit and every interrupt flag is 0 and `bus_rdata` is 0.
- R2: A bus write to offset 0x04 starts each channel whose bit is 1 in `bus_wdata[3:0]`, visible on `ch_run` one cycle after the write. Bits written as 0, and bits above the channel count, change nothing.
- R3: A bus write to offset 0x08 with bit n set on a running channel n only marks a pending stop. `ch_run[n]` stays 1 until a cycle with `ch_period_end[n]` high, and is 0 from the following cycle.
- R4: A start write for channel n while its stop is pending cancels the stop, so a later period end leaves the channel running.
- R5: When a pending stop completes in the same cycle as a start write for that channel, the stop wins and the channel ends up stopped.
- R6: A read of offset 0x0C returns the running bits in [3:0] and 0 above, so 0x0F with all four channels on. Writes to 0x0C have no effect.
- R7: Each `ch_update_done[n]` pulse sets flag n. A read of offset 0x1C returns the flags in [3:0] and clears them all.
- R8: An update-done pulse in the same cycle as a read of 0x1C is not part of that read's data and remains set for the next read.
- R9: An access to 0x200 + n*0x20 + k (k < 0x20) raises only `ch_wr_en[n]` or `ch_rd_en[n]` with `ch_reg_off` = k in that cycle. A read returns word n of `ch_rdata` on `bus_rdata` in the next cycle.
- R10: Reads of any offset other than 0x0C, 0x1C and the channel windows, including the write-only 0x04 and 0x08, return 0. Writes to unmapped offsets change no state and raise no channel strobe.
- R11: `bus_rdata` carries the data of a read for exactly one cycle, the cycle after `bus_rd`, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (10) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data, valid the cycle after `bus_rd` |
| ch_run | output | NUM_CH (4) | Running bit per channel |
| ch_period_end | input | NUM_CH (4) | Per-channel end-of-period pulse from the waveform logic |
| ch_update_done | input | NUM_CH (4) | Per-channel update-done event pulse |
| ch_wr_en | output | NUM_CH (4) | One-hot write strobe into a channel window |
| ch_rd_en | output | NUM_CH (4) | One-hot read strobe into a channel window |
| ch_reg_off | output | OFF_W (5) | Byte offset inside the addressed window |
| ch_rdata | input | NUM_CH*DATA_W (128) | Read data of all channel windows, channel n in word n |

## Verification
The hardest cases are collisions of independent sources within a single cycle. One is a pending stop whose period end lands in the cycle of a start write for the same channel. Another is an update-done event arriving in the cycle the flag word is read. The bench drives the period-end and event inputs in the same negative-edge step as the bus strobe, so both reach the same clock edge. It then reads the status and flag words back to show which side won. Cancelled stops are shown by pulsing the period end after a re-start and confirming the running bit survives.

// File: rtl/pwm_ctl_pkg.sv
// Package: register offsets of the control bank and the decode result type.
// Assumes byte offsets on the bus; the offsets are fixed by the software map.
package pwm_ctl_pkg;
    localparam int OFF_ENA = 'h04;  // write-one-to-start
    localparam int OFF_DIS = 'h08;  // write-one-to-stop (deferred)
    localparam int OFF_STS = 'h0C;  // running bits, read only
    localparam int OFF_ISR = 'h1C;  // update-done flags, clear on read

    typedef struct packed {
        logic ena;
        logic dis;
        logic sts;
        logic isr;
        logic win;
    } hit_t;
endpackage

// File: rtl/pwm_ctl_decode.sv
// Address decoder: classifies a bus offset into one of the global registers
// or a per-channel window, and splits window offsets into channel index and
// local offset. Assumes CH_STRIDE is a power of two and CH_BASE is aligned to
// NUM_CH*CH_STRIDE.
module pwm_ctl_decode
    import pwm_ctl_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int NUM_CH    = 4,
    parameter int CH_BASE   = 'h200,
    parameter int CH_STRIDE = 'h20,
    parameter int IDX_W     = 2,
    parameter int OFF_W     = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit,
    output logic [IDX_W-1:0]  win_idx,
    output logic [OFF_W-1:0]  win_off
);
    localparam int WIN_END = CH_BASE + NUM_CH * CH_STRIDE;
    localparam int REL_W   = OFF_W + IDX_W;

    logic [REL_W-1:0] rel;

    // Compare the offset against each global register and the window range.
    always_comb begin
        rel     = addr[REL_W-1:0] - REL_W'(CH_BASE);
        hit.ena = (addr == ADDR_W'(OFF_ENA));
        hit.dis = (addr == ADDR_W'(OFF_DIS));
        hit.sts = (addr == ADDR_W'(OFF_STS));
        hit.isr = (addr == ADDR_W'(OFF_ISR));
        hit.win = (int'(addr) >= CH_BASE) && (int'(addr) < WIN_END);
        win_idx = rel[OFF_W +: IDX_W];
        win_off = rel[OFF_W-1:0];
    end
endmodule

// File: rtl/pwm_ctl_run.sv
// Run-state keeper: one running bit and one pending-stop bit per channel.
// A start sets the channel and cancels a pending stop; a stop on a running
// channel is held until that channel's period end; a stop completing at a
// period end takes precedence over a start in the same cycle.
module pwm_ctl_run #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] start_req,
    input  logic [NUM_CH-1:0] stop_req,
    input  logic [NUM_CH-1:0] period_end,
    output logic [NUM_CH-1:0] run
);
    logic [NUM_CH-1:0] pend;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Advance the run/pending-stop state of one channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run[g]  <= 1'b0;
                pend[g] <= 1'b0;
            end else if (pend[g] && period_end[g]) begin
                run[g]  <= 1'b0;
                pend[g] <= 1'b0;
            end else if (start_req[g]) begin
                run[g]  <= 1'b1;
                pend[g] <= 1'b0;
            end else if (stop_req[g] && run[g]) begin
                pend[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_ctl_irq.sv
// Update-done flag word: latches event pulses per channel and clears on a
// read strobe, keeping any event that arrives in the clearing cycle.
module pwm_ctl_irq #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt,
    input  logic              clr,
    output logic [NUM_CH-1:0] flags
);
    // Accumulate events; a clear drops only the previously latched ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (clr ? '0 : flags) | evt;
        end
    end
endmodule

// File: rtl/pwm_ctl_bank.sv
// Top of the PWM control bank: decodes the register bus, drives the
// start/stop state and the update-done flags, routes window accesses to the
// channel blocks and registers the read data. Assumes at most one bus access
// kind per register per cycle and single-cycle strobes from the master.
module pwm_ctl_bank
    import pwm_ctl_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    parameter int CH_BASE   = 'h200,
    parameter int CH_STRIDE = 'h20,
    parameter int OFF_W     = $clog2(CH_STRIDE)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_CH-1:0]        ch_run,
    input  logic [NUM_CH-1:0]        ch_period_end,
    input  logic [NUM_CH-1:0]        ch_update_done,
    output logic [NUM_CH-1:0]        ch_wr_en,
    output logic [NUM_CH-1:0]        ch_rd_en,
    output logic [OFF_W-1:0]         ch_reg_off,
    input  logic [NUM_CH*DATA_W-1:0] ch_rdata
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    hit_t              hit;
    logic [IDX_W-1:0]  win_idx;
    logic [NUM_CH-1:0] start_req;
    logic [NUM_CH-1:0] stop_req;
    logic [NUM_CH-1:0] flags;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_CH];

    pwm_ctl_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CH   (NUM_CH),
        .CH_BASE  (CH_BASE),
        .CH_STRIDE(CH_STRIDE),
        .IDX_W    (IDX_W),
        .OFF_W    (OFF_W)
    ) i_decode (
        .addr   (bus_addr),
        .hit    (hit),
        .win_idx(win_idx),
        .win_off(ch_reg_off)
    );

    // Qualify the written bit masks with the register they address.
    always_comb begin
        start_req = (bus_wr && hit.ena) ? bus_wdata[NUM_CH-1:0] : '0;
        stop_req  = (bus_wr && hit.dis) ? bus_wdata[NUM_CH-1:0] : '0;
    end

    pwm_ctl_run #(.NUM_CH(NUM_CH)) i_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .period_end(ch_period_end),
        .run       (ch_run)
    );

    pwm_ctl_irq #(.NUM_CH(NUM_CH)) i_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (ch_update_done),
        .clr  (bus_rd && hit.isr),
        .flags(flags)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
        assign ch_wr_en[g] = bus_wr && hit.win && (win_idx == IDX_W'(g));
        assign ch_rd_en[g] = bus_rd && hit.win && (win_idx == IDX_W'(g));
    end

    // Register the read data for one cycle after each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_rd) begin
            bus_rdata <= '0;
        end else if (hit.sts) begin
            bus_rdata <= DATA_W'(ch_run);
        end else if (hit.isr) begin
            bus_rdata <= DATA_W'(flags);
        end else if (hit.win) begin
            bus_rdata <= ch_rdata[int'(win_idx)*DATA_W +: DATA_W];
        end else begin
            bus_rdata <= '0;
        end
    end
endmodule

// File: rtl/pwm_ctl_bank_chk.sv
// Checker for pwm_ctl_bank, attached by bind. Observes only the ports.
module pwm_ctl_bank_chk
    import pwm_ctl_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    parameter int CH_BASE   = 'h200,
    parameter int CH_STRIDE = 'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [NUM_CH-1:0] wbits,
    input logic              wr,
    input logic              rd,
    input logic [DATA_W-1:0] rdata,
    input logic [NUM_CH-1:0] run,
    input logic [NUM_CH-1:0] pend_end,
    input logic [NUM_CH-1:0] wr_en,
    input logic [NUM_CH-1:0] rd_en
);
    localparam int WIN_END = CH_BASE + NUM_CH * CH_STRIDE;

    logic [NUM_CH-1:0] start_mask;
    logic              mapped;

    // Expected start mask and read-mapped flag derived from the bus alone.
    always_comb begin
        start_mask = (wr && addr == ADDR_W'(OFF_ENA)) ? wbits : '0;
        mapped     = (addr == ADDR_W'(OFF_STS)) || (addr == ADDR_W'(OFF_ISR)) ||
                     ((int'(addr) >= CH_BASE) && (int'(addr) < WIN_END));
    end

    assert_start_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((run & ~$past(run) & ~$past(start_mask)) == '0));

    assert_stop_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((~run & $past(run) & ~$past(pend_end)) == '0));

    assert_status_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rd && addr == ADDR_W'(OFF_STS)) |-> (rdata == DATA_W'($past(run))));

    assert_window_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en) && $onehot0(rd_en) &&
        ((wr_en == '0) || wr) && ((rd_en == '0) || rd));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rd && !mapped) |-> (rdata == '0));

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !rd) |-> (rdata == '0));
endmodule

bind pwm_ctl_bank pwm_ctl_bank_chk #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CH_BASE  (CH_BASE),
    .CH_STRIDE(CH_STRIDE)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .wbits   (bus_wdata[NUM_CH-1:0]),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .rdata   (bus_rdata),
    .run     (ch_run),
    .pend_end(ch_period_end),
    .wr_en   (ch_wr_en),
    .rd_en   (ch_rd_en)
);

// File: tb/test_pwm_ctl_bank.sv
`timescale 1ns/1ps
module test_pwm_ctl_bank;
    localparam int NUM_CH = 4;
    localparam int DATA_W = 32;
    localparam int NVEC   = 19;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [9:0]               bus_addr = '0;
    logic [31:0]              bus_wdata = '0;
    logic                     bus_wr = 1'b0;
    logic                     bus_rd = 1'b0;
    logic [31:0]              bus_rdata;
    logic [3:0]               ch_run;
    logic [3:0]               ch_period_end = '0;
    logic [3:0]               ch_update_done = '0;
    logic [3:0]               ch_wr_en;
    logic [3:0]               ch_rd_en;
    logic [4:0]               ch_reg_off;
    logic [NUM_CH*DATA_W-1:0] ch_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_src
        assign ch_rdata[g*DATA_W +: DATA_W] = 32'hA0A0_0000 + g;
    end

    pwm_ctl_bank i_pwm_ctl_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ch_run(ch_run),
        .ch_period_end(ch_period_end), .ch_update_done(ch_update_done),
        .ch_wr_en(ch_wr_en), .ch_rd_en(ch_rd_en), .ch_reg_off(ch_reg_off),
        .ch_rdata(ch_rdata)
    );

    // Vector: op[79:78] (0 write, 1 read-check), addr[77:68], data[67:36],
    // expected[35:4], tag[3:0] (1=R1, 2=R2, 3=R3, 6=R6, 10=R10).
    localparam logic [79:0] VEC [NVEC] = '{
        {2'd1, 10'h00C, 32'h0,         32'h0,  4'd1},
        {2'd0, 10'h004, 32'h1,         32'h0,  4'd0},
        {2'd1, 10'h00C, 32'h0,         32'h1,  4'd2},
        {2'd0, 10'h004, 32'h0,         32'h0,  4'd0},
        {2'd1, 10'h00C, 32'h0,         32'h1,  4'd2},
        {2'd0, 10'h004, 32'hA,         32'h0,  4'd0},
        {2'd1, 10'h00C, 32'h0,         32'hB,  4'd2},
        {2'd0, 10'h004, 32'hFFFF_FFF0, 32'h0,  4'd0},
        {2'd1, 10'h00C, 32'h0,         32'hB,  4'd2},
        {2'd0, 10'h00C, 32'hF,         32'h0,  4'd0},
        {2'd1, 10'h00C, 32'h0,         32'hB,  4'd6},
        {2'd0, 10'h004, 32'h4,         32'h0,  4'd0},
        {2'd1, 10'h00C, 32'h0,         32'hF,  4'd6},
        {2'd0, 10'h010, 32'hF,         32'h0,  4'd0},
        {2'd1, 10'h010, 32'h0,         32'h0,  4'd10},
        {2'd1, 10'h004, 32'h0,         32'h0,  4'd10},
        {2'd1, 10'h3FC, 32'h0,         32'h0,  4'd10},
        {2'd0, 10'h008, 32'h3,         32'h0,  4'd0},
        {2'd1, 10'h00C, 32'h0,         32'hF,  4'd3}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd6:    return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_end(input logic [3:0] m);
        ch_period_end = m;
        @(negedge clk);
        ch_period_end = '0;
    endtask

    task automatic pulse_evt(input logic [3:0] m);
        ch_update_done = m;
        @(negedge clk);
        ch_update_done = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1 run after reset", 32'(ch_run), 32'h0);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][79:78] == 2'd0) begin
                bus_write(VEC[i][77:68], VEC[i][67:36]);
            end else begin
                bus_read(VEC[i][77:68], rd);
                check(tag_name(VEC[i][3:0]), rd, VEC[i][35:4]);
            end
        end

        // R3: pending stops on channels 0 and 1 resolve only at their boundary
        pulse_end(4'h1);
        check("R3 stop at boundary", 32'(ch_run), 32'hE);

        // R4: re-start of channel 1 cancels its pending stop
        bus_write(10'h004, 32'h2);
        pulse_end(4'h2);
        check("R4 cancelled stop", 32'(ch_run), 32'hE);

        // R5: stop completes in the cycle of a start write, stop wins
        bus_write(10'h008, 32'h4);
        check("R3 stop pending keeps run", 32'(ch_run), 32'hE);
        bus_addr = 10'h004; bus_wdata = 32'h4; bus_wr = 1'b1; ch_period_end = 4'h4;
        @(negedge clk);
        bus_wr = 1'b0; ch_period_end = '0;
        check("R5 stop beats start", 32'(ch_run), 32'hA);

        // R7: flags latch and clear on read
        pulse_evt(4'h5);
        bus_read(10'h01C, rd);
        check("R7 flags read", rd, 32'h5);
        bus_read(10'h01C, rd);
        check("R7 flags cleared", rd, 32'h0);

        // R8: event during the clearing read survives
        pulse_evt(4'h1);
        bus_addr = 10'h01C; bus_rd = 1'b1; ch_update_done = 4'h8;
        @(negedge clk);
        bus_rd = 1'b0; ch_update_done = '0;
        check("R8 read excludes same-cycle event", bus_rdata, 32'h1);
        bus_read(10'h01C, rd);
        check("R8 same-cycle event kept", rd, 32'h8);

        // R9: window strobes, local offset and read routing
        bus_addr = 10'h244; bus_wr = 1'b1;
        #1;
        check("R9 write strobe", 32'(ch_wr_en), 32'h4);
        check("R9 local offset", 32'(ch_reg_off), 32'h4);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = 10'h26C; bus_rd = 1'b1;
        #1;
        check("R9 read strobe", 32'(ch_rd_en), 32'h8);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R9 window read data", bus_rdata, 32'hA0A0_0003);

        // R10: write past the last window raises no strobe and changes nothing
        bus_addr = 10'h280; bus_wdata = 32'hF; bus_wr = 1'b1;
        #1;
        check("R10 no strobe past windows", 32'(ch_wr_en), 32'h0);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10 run unchanged", 32'(ch_run), 32'hA);
        bus_read(10'h280, rd);
        check("R10 read past windows", rd, 32'h0);

        // R11: read data lasts one cycle only
        @(negedge clk);
        check("R11 rdata idle", bus_rdata, 32'h0);

        // R1: mid-run reset clears run and flags
        pulse_evt(4'h3);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 run after second reset", 32'(ch_run), 32'h0);
        bus_read(10'h01C, rd);
        check("R1 flags after second reset", rd, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule